// File: doc/BRIEF.md
# Unaligned Load/Store Access Unit

This unit sits between a processor's load/store stage and a 32-bit, word-addressed memory port with per-byte write enables. It takes one request at a time: a byte, halfword or word, read or write, signed or unsigned, at any byte address. It then issues one or two aligned memory transactions. When a request crosses into the next word, the unit fetches or writes the lower word first and then the following word. For loads, it joins the two results, shifts them down to bit 0 and extends them to 32 bits.

A mode input chooses between strict alignment and packed data. In strict mode, a halfword at an odd address or a word at an address that is not a multiple of four is refused with a one-cycle fault pulse, and the memory port stays quiet. In packed mode, any byte address is accepted, so variables can be laid out back to back without padding.

Top module: `lsu_align_unit`

## Requirements
- R1: After reset, busy, done, fault and mem_req are all low.
- R2: When strict_mode is 1, a halfword request whose address bit 0 is 1, or a word request whose two low address bits are not 00, produces fault high for exactly the cycle after acceptance. No memory transaction is issued, memory contents are unchanged, and done does not pulse.
- R3: Byte requests at any address, and requests aligned to their own size, never fault in either mode. In packed mode (strict_mode 0), halfword and word requests at any address do not fault.
- R4: Size is encoded on req_size as 0 for byte, 1 for halfword and 2 for word. Code 3 is reserved and always faults, in both modes, without any memory transaction.
- R5: Byte enables are little-endian. Bit k of mem_be selects the byte at word address plus k, and during each transaction exactly the lanes of the bytes being accessed in that word are set.
- R6: A request whose bytes all lie in one aligned word uses one transaction at the address with its two low bits cleared. A request that spills into the next word uses two transactions: first at that aligned address, then at the aligned address plus 4.
- R7: For a store of N bytes (N = 1, 2 or 4), byte i of req_wdata (bits 8i+7..8i) is written to byte address req_addr + i, and no other memory byte changes.
- R8: For a load, result byte i is the memory byte at req_addr + i. Byte and halfword results are sign-extended when req_signed is 1 and zero-extended otherwise. Word results are returned unchanged.
- R9: busy is high from the cycle after acceptance until the last transaction is acknowledged. done is a one-cycle pulse in the cycle after that acknowledge, with rdata valid in the same cycle. A request presented while busy is ignored.
- R10: While mem_req is high and mem_ack is low, mem_req, mem_addr and mem_be stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_mode | input | 1 | 1 = trap on misaligned halfword/word, 0 = packed access allowed |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend narrow load results |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Store data, right-justified |
| busy | output | 1 | Transaction sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle misalignment or reserved-size pulse |
| rdata | output | 32 | Extended load result, valid with done |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-rotated store data |
| mem_ack | input | 1 | Memory transaction complete |
| mem_rdata | input | 32 | Memory read word, valid with mem_ack |

## Verification
The hardest case to provoke is a second transaction that must carry state from the first. A signed halfword at offset 3, or a word at offsets 1 to 3, has its sign bit only in the second word, and the ignored request must land in the middle of such a split. The stimulus sweeps every size code against eight consecutive byte offsets, so that all four lane positions are covered in both the fitting and the spilling form. It does this in both modes and for loads and stores, with memory latency rotating through 0 to 2 wait cycles. On every other operation it also raises a conflicting store in the cycle after acceptance.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } lsu_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } lsu_state_e;

  // Number of bytes moved by a size code (reserved code counts as a word).
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Request must be refused: reserved size, or misaligned under strict mode.
  function automatic logic needs_fault(input logic strict, input logic [1:0] sz,
                                       input logic [1:0] off);
    logic odd_half, odd_word;
    odd_half = (sz == SZ_HALF) && off[0];
    odd_word = (sz == SZ_WORD) && (off != 2'b00);
    needs_fault = (sz == SZ_RSVD) || (strict && (odd_half || odd_word));
  endfunction

  // Right-justified raw value to architectural load result.
  function automatic logic [WORD_W-1:0] extend_load(input logic [WORD_W-1:0] v,
                                                    input logic [1:0] sz,
                                                    input logic sgn);
    case (sz)
      SZ_BYTE: extend_load = {{(WORD_W-8){sgn & v[7]}}, v[7:0]};
      SZ_HALF: extend_load = {{(WORD_W-16){sgn & v[15]}}, v[15:0]};
      default: extend_load = v;
    endcase
  endfunction

endpackage

// File: rtl/lsu_lane_plan.sv
module lsu_lane_plan
  import lsu_pkg::*;
#(
  parameter int LANES = WORD_BYTES
) (
  input  logic [$clog2(LANES)-1:0] off,
  input  logic [1:0]               size,
  output logic [LANES-1:0]         be_lo,
  output logic [LANES-1:0]         be_hi,
  output logic                     split
);
  localparam int OFF_W = $clog2(LANES);

  logic [2:0] nbytes;
  int         first_lane;
  int         end_lane;

  assign nbytes     = size_bytes(size);
  assign first_lane = int'(off);
  assign end_lane   = int'(off) + int'(nbytes);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_lo[i] = (i >= first_lane) && (i < end_lane);
    assign be_hi[i] = (i + LANES) < end_lane;
  end

  assign split = |be_hi;

  logic unused_ok;
  assign unused_ok = &{1'b0, OFF_W[0]};
endmodule

// File: rtl/lsu_store_rotate.sv
module lsu_store_rotate
  import lsu_pkg::*;
#(
  parameter int LANES = WORD_BYTES
) (
  input  logic [8*LANES-1:0]       wdata,
  input  logic [$clog2(LANES)-1:0] off,
  output logic [8*LANES-1:0]       lo_word,
  output logic [8*LANES-1:0]       hi_word
);
  localparam int W = 8 * LANES;

  logic [2*W-1:0] wide;
  assign wide    = {{W{1'b0}}, wdata} << {off, 3'b000};
  assign lo_word = wide[W-1:0];
  assign hi_word = wide[2*W-1:W];
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
  import lsu_pkg::*;
#(
  parameter int LANES = WORD_BYTES
) (
  input  logic [8*LANES-1:0]       lo_word,
  input  logic [8*LANES-1:0]       hi_word,
  input  logic [$clog2(LANES)-1:0] off,
  input  logic [1:0]               size,
  input  logic                     sgn,
  output logic [WORD_W-1:0]        result
);
  localparam int W = 8 * LANES;

  logic [2*W-1:0] joined;
  logic [2*W-1:0] shifted;

  assign joined  = {hi_word, lo_word};
  assign shifted = joined >> {off, 3'b000};
  assign result  = extend_load(shifted[WORD_W-1:0], size, sgn);

  logic unused_ok;
  assign unused_ok = &{1'b0, shifted[2*W-1:WORD_W]};
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strict_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [WORD_W-1:0] rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_BYTES-1:0] mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int LANES = WORD_BYTES;
  localparam int OFF_W = $clog2(LANES);
  localparam int WA_W  = ADDR_W - OFF_W;

  lsu_state_e        state_q;
  logic              write_q, signed_q, split_q;
  logic [1:0]        size_q;
  logic [OFF_W-1:0]  off_q;
  logic [WA_W-1:0]   word_q;
  logic [LANES-1:0]  be_lo_q, be_hi_q;
  logic [WORD_W-1:0] wlo_q, whi_q, lo_data_q, rdata_q;
  logic              done_q, fault_q;

  // Request-side decode
  logic [OFF_W-1:0]  req_off;
  logic [LANES-1:0]  plan_be_lo, plan_be_hi;
  logic              plan_split;
  logic [WORD_W-1:0] rot_lo, rot_hi;
  logic              req_bad;

  assign req_off = req_addr[OFF_W-1:0];
  assign req_bad = needs_fault(strict_mode, req_size, req_off);

  lsu_lane_plan #(.LANES(LANES)) u_plan (
    .off   (req_off),
    .size  (req_size),
    .be_lo (plan_be_lo),
    .be_hi (plan_be_hi),
    .split (plan_split)
  );

  lsu_store_rotate #(.LANES(LANES)) u_rot (
    .wdata   (req_wdata),
    .off     (req_off),
    .lo_word (rot_lo),
    .hi_word (rot_hi)
  );

  // Named events for the checker
  logic accept, launch, trap, phase_second, last_ack;
  assign accept       = req_valid && (state_q == ST_IDLE);
  assign launch       = accept && !req_bad;
  assign trap         = accept && req_bad;
  assign phase_second = (state_q == ST_HI);
  assign last_ack     = mem_ack && (phase_second || ((state_q == ST_LO) && !split_q));

  // Load assembly
  logic [WORD_W-1:0] merge_lo, merge_hi, merged;
  assign merge_lo = phase_second ? lo_data_q : mem_rdata;
  assign merge_hi = phase_second ? mem_rdata : '0;

  lsu_load_merge #(.LANES(LANES)) u_merge (
    .lo_word (merge_lo),
    .hi_word (merge_hi),
    .off     (off_q),
    .size    (size_q),
    .sgn     (signed_q),
    .result  (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      write_q   <= 1'b0;
      signed_q  <= 1'b0;
      split_q   <= 1'b0;
      size_q    <= 2'd0;
      off_q     <= '0;
      word_q    <= '0;
      be_lo_q   <= '0;
      be_hi_q   <= '0;
      wlo_q     <= '0;
      whi_q     <= '0;
      lo_data_q <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      done_q  <= last_ack;
      fault_q <= trap;
      if (last_ack) rdata_q <= merged;
      case (state_q)
        ST_IDLE: begin
          if (launch) begin
            write_q  <= req_write;
            signed_q <= req_signed;
            split_q  <= plan_split;
            size_q   <= req_size;
            off_q    <= req_off;
            word_q   <= req_addr[ADDR_W-1:OFF_W];
            be_lo_q  <= plan_be_lo;
            be_hi_q  <= plan_be_hi;
            wlo_q    <= rot_lo;
            whi_q    <= rot_hi;
            state_q  <= ST_LO;
          end
        end
        ST_LO: begin
          if (mem_ack) begin
            if (split_q) begin
              lo_data_q <= mem_rdata;
              state_q   <= ST_HI;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_HI: begin
          if (mem_ack) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [WA_W-1:0] word_sel;
  assign word_sel  = phase_second ? (word_q + 1'b1) : word_q;

  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = mem_req && write_q;
  assign mem_addr  = {word_sel, {OFF_W{1'b0}}};
  assign mem_be    = phase_second ? be_hi_q : ((state_q == ST_LO) ? be_lo_q : '0);
  assign mem_wdata = phase_second ? whi_q : ((state_q == ST_LO) ? wlo_q : '0);

  assign busy  = mem_req;
  assign done  = done_q;
  assign fault = fault_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/lsu_align_checker.sv
module lsu_align_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              done,
  input logic              fault,
  input logic              busy,
  input logic              phase_second,
  input logic              launch,
  input logic              trap
);

  // R2: a refused request pulses fault and leaves the memory port idle
  p_trap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> fault && !mem_req);

  // R2: a fault never coincides with a completion
  p_fault_not_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !done);

  // R5: every issued transaction enables at least one lane
  p_lanes_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != 4'b0000));

  // R6: the second transaction targets the following word
  p_next_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_second) |-> (mem_addr == ($past(mem_addr) + ADDR_W'(4))));

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: an accepted legal request makes the unit busy
  p_launch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R10: an unacknowledged transaction is held steady
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)));

endmodule

bind lsu_align_unit lsu_align_checker #(.ADDR_W(ADDR_W)) u_align_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .mem_be       (mem_be),
  .done         (done),
  .fault        (fault),
  .busy         (busy),
  .phase_second (phase_second),
  .launch       (launch),
  .trap         (trap)
);

// File: tb/test_lsu_align_unit.sv
`timescale 1ns/1ps
module test_lsu_align_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strict_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_signed = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, fault;
  logic [31:0] rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  lsu_align_unit i_lsu_align_unit (
    .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .fault(fault), .rdata(rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  function automatic logic [7:0] pat(input int i);
    pat = 8'((i * 73 + 29) ^ (i << 4));
  endfunction

  // Memory model: 64 bytes, configurable wait cycles
  logic [7:0] mem_b [0:63];
  logic [7:0] ref_b [0:63];
  int lat = 0;
  int wcnt = 0;
  int wbase;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
      for (int i = 0; i < 64; i++) mem_b[i] <= pat(i);
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        wcnt    <= 0;
        mem_ack <= 1'b1;
        wbase = 4 * int'(mem_addr[5:2]);
        for (int k = 0; k < 4; k++)
          if (mem_we && mem_be[k]) mem_b[wbase + k] <= mem_wdata[8*k +: 8];
        mem_rdata <= {mem_b[wbase+3], mem_b[wbase+2], mem_b[wbase+1], mem_b[wbase]};
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // Transaction monitor
  int          tcnt = 0;
  logic [31:0] t_addr [0:3];
  logic [3:0]  t_be   [0:3];
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      t_addr[tcnt % 4] <= mem_addr;
      t_be[tcnt % 4]   <= mem_be;
      tcnt <= tcnt + 1;
    end
  end

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit strict, input bit wr, input logic [1:0] sz,
                        input bit sgn, input int addr, input logic [31:0] wd,
                        input int latency, input bit meddle);
    bit          exp_fault, got_fault, got_done, seen_busy;
    int          nb, off, exp_n, start, mism;
    logic [31:0] got_rd, exp_rd, raw;
    logic [3:0]  exp_be0, exp_be1;
    string       ftag;

    exp_fault = (sz == 2'd3) ||
                (strict && ((sz == 2'd1 && (addr % 2) != 0) ||
                            (sz == 2'd2 && (addr % 4) != 0)));
    nb    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    off   = addr % 4;
    exp_n = exp_fault ? 0 : ((off + nb > 4) ? 2 : 1);
    ftag  = (sz == 2'd3) ? "R4" : (exp_fault ? "R2" : "R3");

    @(negedge clk);
    lat         = latency;
    start       = tcnt;
    strict_mode = strict;
    req_valid   = 1'b1;
    req_write   = wr;
    req_size    = sz;
    req_signed  = sgn;
    req_addr    = 32'(addr);
    req_wdata   = wd;
    got_fault = 0; got_done = 0; seen_busy = 0; got_rd = '0;

    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k == 0) begin
        seen_busy = busy;
        if (meddle && !exp_fault) begin
          // conflicting store while busy: must be ignored (R9)
          req_write = 1'b1; req_size = 2'd2; req_addr = 32'd4; req_wdata = 32'hDEAD_BEEF;
        end else begin
          req_valid = 1'b0;
        end
      end else begin
        req_valid = 1'b0;
      end
      if (fault) got_fault = 1;
      if (done) begin got_done = 1; got_rd = rdata; end
      if (fault || done) break;
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(!done && !fault, "R9 pulse", {30'b0, done, fault}, 32'h0);

    chk(got_fault == exp_fault, ftag, 32'(got_fault), 32'(exp_fault));
    chk(got_done == !exp_fault, "R9 done", 32'(got_done), 32'(!exp_fault));
    chk((tcnt - start) == exp_n, exp_fault ? ftag : "R6 count", 32'(tcnt - start), 32'(exp_n));
    if (!exp_fault) chk(seen_busy, "R9 busy", 32'(seen_busy), 32'h1);

    exp_be0 = '0; exp_be1 = '0;
    for (int k = 0; k < nb; k++) begin
      if ((addr + k) / 4 == addr / 4) exp_be0[(addr + k) % 4] = 1'b1;
      else                            exp_be1[(addr + k) % 4] = 1'b1;
    end
    if (exp_n >= 1 && (tcnt - start) >= 1) begin
      chk(t_addr[start % 4] == 32'(addr & ~3), "R6 first addr", t_addr[start % 4], 32'(addr & ~3));
      chk(t_be[start % 4] == exp_be0, "R5 first lanes", 32'(t_be[start % 4]), 32'(exp_be0));
    end
    if (exp_n == 2 && (tcnt - start) == 2) begin
      chk(t_addr[(start + 1) % 4] == 32'((addr & ~3) + 4), "R6 second addr",
          t_addr[(start + 1) % 4], 32'((addr & ~3) + 4));
      chk(t_be[(start + 1) % 4] == exp_be1, "R5 second lanes",
          32'(t_be[(start + 1) % 4]), 32'(exp_be1));
    end

    if (wr && !exp_fault)
      for (int k = 0; k < nb; k++) ref_b[addr + k] = wd[8*k +: 8];

    if (wr || exp_fault) begin
      mism = 0;
      for (int i = 0; i < 64; i++) if (mem_b[i] !== ref_b[i]) mism++;
      chk(mism == 0, exp_fault ? "R2 memory untouched" : "R7 store bytes", 32'(mism), 32'h0);
    end else begin
      raw = '0;
      for (int k = 0; k < nb; k++) raw[8*k +: 8] = ref_b[addr + k];
      if (nb == 1)      exp_rd = (sgn && raw[7])  ? (raw | 32'hFFFF_FF00) : raw;
      else if (nb == 2) exp_rd = (sgn && raw[15]) ? (raw | 32'hFFFF_0000) : raw;
      else              exp_rd = raw;
      chk(got_rd == exp_rd, "R8 load data", got_rd, exp_rd);
    end
  endtask

  initial begin : watchdog
    while (cycles < 150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int n;
    for (int i = 0; i < 64; i++) ref_b[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1 reset state",
        {28'b0, busy, done, fault, mem_req}, 32'h0);

    n = 0;
    for (int md = 0; md < 2; md++)
      for (int wr = 1; wr >= 0; wr--)
        for (int sz = 0; sz < 4; sz++)
          for (int o = 0; o < 8; o++)
            for (int sg = 0; sg < 2; sg++) begin
              run_op(md[0], wr[0], 2'(sz), sg[0], 16 + o + 8 * sz,
                     32'h9E37_79B9 * 32'(n + 1), n % 3, n[0]);
              n++;
            end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule